// File: doc/BRIEF.md
# Accumulator Machine Fetch-Execute Controller

This block is a small hardwired processor core built around one 16-bit accumulator and a 12-bit word address space. Instructions and data share a single 4096-word memory. The core fetches one instruction word at a time. It splits the word into an operation code and an operand, and then carries the instruction out. All memory traffic, for instruction fetch and for data, goes through two internal buffers: an address buffer that drives the memory address lines and a data buffer that holds read or write data.

The next step after a fetch is chosen by combinational decode logic. This logic looks only at the operation code and at two status bits of the accumulator: its sign (negative) and whether it is zero. The core drives a plain synchronous memory port. The memory returns read data one clock after the read strobe. The core supports direct load, store, add and subtract, an immediate load, unconditional and conditional jumps, and a halt. After a halt it stays idle until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, and in the cycle it is released, halted, mem_rd and mem_wr are low. The first read after reset is an instruction fetch from address 0x100.
- R2: An instruction word carries its operation code in bits 15:12 and its operand in bits 11:0. After each fetch the program counter moves to the next word, so instructions run in address order unless a jump is taken.
- R3: Code 0 loads the word at the operand address into the accumulator. Code 1 writes the accumulator to the operand address through a single mem_wr pulse.
- R4: Code 2 adds the word at the operand address to the accumulator, and code 3 subtracts that word from it. Both results wrap modulo 2^16.
- R5: Code 7 loads the 12-bit operand into the accumulator with zeros in bits 15:12.
- R6: Code 6 always continues execution at the operand address.
- R7: Code 4 continues at the operand address when accumulator bit 15 is 0 (value zero or positive). Otherwise it falls through to the next word.
- R8: Code 5 continues at the operand address when the accumulator is exactly zero. Otherwise it falls through.
- R9: Codes 8 to 14 change neither the accumulator nor memory. Execution goes on with the next word.
- R10: Code 15 raises halted. Halted then stays high, and both strobes stay low, until reset. No instruction after the halt is executed.
- R11: mem_rd and mem_wr are never high in the same cycle. A read strobe is never held for two cycles in a row, and neither is a write strobe. Read data is taken one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory word address, driven from the address buffer |
| mem_wdata | output | 16 | Write data, driven from the data buffer |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High once a halt instruction has run |

## Verification
The arithmetic path is driven by a table of operand pairs run through a load, add-or-subtract, store sequence. The pairs include zero, carry-out wrap, signed-overflow crossings and a borrow below zero, which separate correct 16-bit modular results from truncated or sign-confused ones. The conditional jumps run a pass-mark program on values above, equal to and below the threshold, and a zero test on zero, one and the most negative value. This pins the boundary between sign and zero conditions. Directed programs cover the unconditional jump, the zero-extended immediate, the no-operation codes (including a memory word they must not touch), and the halt's hold behaviour with a store placed after it.

// File: rtl/acc_cpu_pkg.sv
// Package: shared encodings for the accumulator core.
// Assumes a 4-bit operation code in the top bits of every instruction word.
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_LOAD  = 4'h0;
    localparam logic [OPC_W-1:0] OP_STORE = 4'h1;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'h2;
    localparam logic [OPC_W-1:0] OP_SUB   = 4'h3;
    localparam logic [OPC_W-1:0] OP_JGE   = 4'h4;
    localparam logic [OPC_W-1:0] OP_JZ    = 4'h5;
    localparam logic [OPC_W-1:0] OP_JMP   = 4'h6;
    localparam logic [OPC_W-1:0] OP_LOADI = 4'h7;
    localparam logic [OPC_W-1:0] OP_HALT  = 4'hF;

    // Class of work an instruction needs after decode
    typedef enum logic [2:0] {
        K_MEMRD,
        K_STORE,
        K_JUMP,
        K_LOADI,
        K_HALT,
        K_NOP
    } op_kind_e;

    // Operation applied when a read operand returns
    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB
    } alu_op_e;

    // Sequencer states
    typedef enum logic [3:0] {
        S_FETCH,
        S_FREAD,
        S_FWAIT,
        S_DECODE,
        S_DREAD,
        S_DWAIT,
        S_EXEC,
        S_DWRITE,
        S_HALT
    } state_e;

endpackage

// File: rtl/acc_cpu_decode.sv
// Module: hardwired instruction decode.
// Maps an operation code plus the accumulator sign and zero bits to a
// work class, an arithmetic selection and a jump-taken flag. Purely
// combinational; assumes the caller presents the code of the current
// instruction.
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic             ac_neg,
    input  logic             ac_zero,
    output op_kind_e         kind,
    output alu_op_e          alu_op,
    output logic             jump_taken
);

    // Decode table: code and status bits to control outputs
    always_comb begin
        kind       = K_NOP;
        alu_op     = ALU_PASS;
        jump_taken = 1'b0;
        case (opc)
            OP_LOAD:  begin kind = K_MEMRD; alu_op = ALU_PASS; end
            OP_STORE: kind = K_STORE;
            OP_ADD:   begin kind = K_MEMRD; alu_op = ALU_ADD; end
            OP_SUB:   begin kind = K_MEMRD; alu_op = ALU_SUB; end
            OP_JGE:   begin kind = K_JUMP; jump_taken = !ac_neg; end
            OP_JZ:    begin kind = K_JUMP; jump_taken = ac_zero; end
            OP_JMP:   begin kind = K_JUMP; jump_taken = 1'b1; end
            OP_LOADI: kind = K_LOADI;
            OP_HALT:  kind = K_HALT;
            default:  kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/acc_cpu_alu.sv
// Module: accumulator arithmetic unit.
// Passes, adds or subtracts the memory operand against the accumulator,
// wrapping modulo 2^DATA_W. Combinational.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] result
);

    // Select the arithmetic result
    always_comb begin
        case (op)
            ALU_ADD: result = acc + opnd;
            ALU_SUB: result = acc - opnd;
            default: result = opnd;
        endcase
    end

endmodule

// File: rtl/acc_cpu.sv
// Module: accumulator core top - sequencer, registers and memory port.
// Runs fetch / decode / execute forever from RESET_PC. Every memory access
// goes through the address buffer (mar_q) and data buffer (mbr_q). Assumes
// a synchronous memory that returns read data one cycle after mem_rd, and
// DATA_W = ADDR_W + 4.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int                 DATA_W   = 16,
    parameter int                 ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]  RESET_PC = 12'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              halted
);

    localparam int          EXT_W = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] PC_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    state_e            state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mbr_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] ac_q;

    logic [OPC_W-1:0]  opc_sel;
    logic [ADDR_W-1:0] operand;
    op_kind_e          kind;
    alu_op_e           alu_op;
    logic              jump_taken;
    logic [DATA_W-1:0] alu_res;

    // Decode reads the fresh word in S_DECODE, the held word afterwards
    always_comb begin
        opc_sel = (state_q == S_DECODE) ? mbr_q[DATA_W-1 -: OPC_W]
                                        : ir_q[DATA_W-1 -: OPC_W];
        operand = mbr_q[ADDR_W-1:0];
    end

    acc_cpu_decode u_decode (
        .opc        (opc_sel),
        .ac_neg     (ac_q[DATA_W-1]),
        .ac_zero    (ac_q == '0),
        .kind       (kind),
        .alu_op     (alu_op),
        .jump_taken (jump_taken)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (alu_op),
        .acc    (ac_q),
        .opnd   (mbr_q),
        .result (alu_res)
    );

    // Memory port driven straight from the buffers and the state
    always_comb begin
        mem_addr  = mar_q;
        mem_wdata = mbr_q;
        mem_rd    = (state_q == S_FREAD) || (state_q == S_DREAD);
        mem_wr    = (state_q == S_DWRITE);
        halted    = (state_q == S_HALT);
    end

    // Sequencer and architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FETCH;
            pc_q    <= RESET_PC;
            mar_q   <= '0;
            mbr_q   <= '0;
            ir_q    <= '0;
            ac_q    <= '0;
        end else begin
            case (state_q)
                S_FETCH: begin
                    mar_q   <= pc_q;
                    state_q <= S_FREAD;
                end
                S_FREAD: begin
                    pc_q    <= pc_q + PC_STEP;
                    state_q <= S_FWAIT;
                end
                S_FWAIT: begin
                    mbr_q   <= mem_rdata;
                    state_q <= S_DECODE;
                end
                S_DECODE: begin
                    ir_q <= mbr_q;
                    case (kind)
                        K_MEMRD: begin
                            mar_q   <= operand;
                            state_q <= S_DREAD;
                        end
                        K_STORE: begin
                            mar_q   <= operand;
                            mbr_q   <= ac_q;
                            state_q <= S_DWRITE;
                        end
                        K_JUMP: begin
                            if (jump_taken) pc_q <= operand;
                            state_q <= S_FETCH;
                        end
                        K_LOADI: begin
                            ac_q    <= {{EXT_W{1'b0}}, operand};
                            state_q <= S_FETCH;
                        end
                        K_HALT:  state_q <= S_HALT;
                        default: state_q <= S_FETCH;
                    endcase
                end
                S_DREAD:  state_q <= S_DWAIT;
                S_DWAIT: begin
                    mbr_q   <= mem_rdata;
                    state_q <= S_EXEC;
                end
                S_EXEC: begin
                    ac_q    <= alu_res;
                    state_q <= S_FETCH;
                end
                S_DWRITE: state_q <= S_FETCH;
                S_HALT:   state_q <= S_HALT;
                default:  state_q <= S_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/acc_cpu_chk.sv
// Module: protocol checker for the accumulator core, bound to acc_cpu.
// Watches only the memory strobes and the halted flag.
module acc_cpu_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_rd,
    input logic mem_wr,
    input logic halted
);

    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11
    rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R11
    wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .halted (halted)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_rd;
    logic        mem_wr;
    logic        halted;

    logic [15:0] mem [0:4095];
    int total = 0;
    int bad = 0;
    int overlap = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted)
    );

    // Synchronous memory model, one cycle read latency
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // R11 strobe overlap monitor
    always @(negedge clk) begin
        cycles++;
        if (rst_n && mem_rd && mem_wr) overlap++;
    end

    // Watchdog
    initial begin
        wait (cycles > 150000);
        $display("FAIL watchdog act=%0d exp=<150000", cycles);
        bad++; total++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] arg);
        return {op, arg};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    // Reset, release, run until halt or timeout
    task automatic run_prog();
        int n;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (!halted) check("R10 halt reached", 16'(n), 16'd0);
    endtask

    // {add_not_sub, a, b}
    localparam logic [32:0] VEC [0:7] = '{
        {1'b1, 16'd5,    16'd7},
        {1'b1, 16'hFFFF, 16'h0001},
        {1'b1, 16'h7FFF, 16'h0001},
        {1'b1, 16'h1234, 16'h4321},
        {1'b0, 16'd10,   16'd3},
        {1'b0, 16'd3,    16'd10},
        {1'b0, 16'h8000, 16'h0001},
        {1'b0, 16'h0000, 16'h0000}
    };

    task automatic pass_mark(input logic [15:0] mark, input logic [15:0] exp);
        clear_mem();
        mem[12'h100] = ins(4'h0, 12'h200);
        mem[12'h101] = ins(4'h3, 12'h201);
        mem[12'h102] = ins(4'h4, 12'h106);
        mem[12'h103] = ins(4'h7, 12'h000);
        mem[12'h104] = ins(4'h1, 12'h203);
        mem[12'h105] = ins(4'hF, 12'h000);
        mem[12'h106] = ins(4'h7, 12'h001);
        mem[12'h107] = ins(4'h1, 12'h203);
        mem[12'h108] = ins(4'hF, 12'h000);
        mem[12'h200] = mark;
        mem[12'h201] = 16'd40;
        mem[12'h203] = 16'hDEAD;
        run_prog();
        check("R7 jump on non-negative", mem[12'h203], exp);
    endtask

    task automatic zero_test(input logic [15:0] val, input logic [15:0] exp);
        clear_mem();
        mem[12'h100] = ins(4'h0, 12'h200);
        mem[12'h101] = ins(4'h5, 12'h105);
        mem[12'h102] = ins(4'h7, 12'h0AA);
        mem[12'h103] = ins(4'h1, 12'h203);
        mem[12'h104] = ins(4'hF, 12'h000);
        mem[12'h105] = ins(4'h7, 12'h0BB);
        mem[12'h106] = ins(4'h1, 12'h203);
        mem[12'h107] = ins(4'hF, 12'h000);
        mem[12'h200] = val;
        run_prog();
        check("R8 jump on zero", mem[12'h203], exp);
    endtask

    initial begin
        // R1 reset state and first fetch address
        clear_mem();
        mem[12'h100] = ins(4'hF, 12'h000);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 halted in reset", {15'd0, halted}, 16'd0);
        check("R1 strobes in reset", {14'd0, mem_rd, mem_wr}, 16'd0);
        rst_n = 1'b1;
        check("R1 strobes at release", {14'd0, mem_rd, mem_wr}, 16'd0);
        while (!mem_rd) @(negedge clk);
        check("R1 first fetch address", {4'd0, mem_addr}, 16'h0100);

        // R3 R4 R2: arithmetic table, load / op / store / halt
        for (int v = 0; v < 8; v++) begin
            logic [15:0] a, b, e;
            a = VEC[v][31:16];
            b = VEC[v][15:0];
            e = VEC[v][32] ? a + b : a - b;
            clear_mem();
            mem[12'h100] = ins(4'h0, 12'h200);
            mem[12'h101] = ins(VEC[v][32] ? 4'h2 : 4'h3, 12'h201);
            mem[12'h102] = ins(4'h1, 12'h202);
            mem[12'h103] = ins(4'hF, 12'h000);
            mem[12'h200] = a;
            mem[12'h201] = b;
            run_prog();
            check("R4 add/sub result (R3 load/store, R2 sequencing)", mem[12'h202], e);
        end

        // R7 threshold above, equal, below
        pass_mark(16'd55, 16'd1);
        pass_mark(16'd40, 16'd1);
        pass_mark(16'd39, 16'd0);

        // R8 zero, one, most negative
        zero_test(16'h0000, 16'h00BB);
        zero_test(16'h0001, 16'h00AA);
        zero_test(16'h8000, 16'h00AA);

        // R6 unconditional jump skips the overwrite
        clear_mem();
        mem[12'h100] = ins(4'h7, 12'h011);
        mem[12'h101] = ins(4'h1, 12'h203);
        mem[12'h102] = ins(4'h6, 12'h105);
        mem[12'h103] = ins(4'h7, 12'h022);
        mem[12'h104] = ins(4'h1, 12'h203);
        mem[12'h105] = ins(4'hF, 12'h000);
        run_prog();
        check("R6 jump always", mem[12'h203], 16'h0011);

        // R5 immediate is zero-extended
        clear_mem();
        mem[12'h100] = ins(4'h7, 12'hFFF);
        mem[12'h101] = ins(4'h1, 12'h203);
        mem[12'h102] = ins(4'hF, 12'h000);
        run_prog();
        check("R5 immediate zero-extend", mem[12'h203], 16'h0FFF);

        // R9 no-op codes leave AC and memory alone
        clear_mem();
        mem[12'h100] = ins(4'h7, 12'h123);
        mem[12'h101] = ins(4'h8, 12'h456);
        mem[12'h102] = ins(4'hE, 12'h456);
        mem[12'h103] = ins(4'h1, 12'h203);
        mem[12'h104] = ins(4'hF, 12'h000);
        mem[12'h456] = 16'h5A5A;
        run_prog();
        check("R9 no-op keeps AC", mem[12'h203], 16'h0123);
        check("R9 no-op keeps memory", mem[12'h456], 16'h5A5A);

        // R10 halt holds, stays quiet, later store not executed
        clear_mem();
        mem[12'h100] = ins(4'h7, 12'h077);
        mem[12'h101] = ins(4'hF, 12'h000);
        mem[12'h102] = ins(4'h1, 12'h203);
        run_prog();
        begin
            int slips;
            slips = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (!halted || mem_rd || mem_wr) slips++;
            end
            check("R10 halt hold cycles", 16'(slips), 16'd0);
        end
        check("R10 nothing after halt", mem[12'h203], 16'h0000);

        // R11 strobe exclusivity over the whole run
        check("R11 strobe overlap", 16'(overlap), 16'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule